// File: doc/BRIEF.md
# Two-Level Masked Interrupt Aggregator

This block gathers interrupt events for a small 8-bit processor core. Seven sources feed it. Three are core sources: an external pin edge, a port-change mismatch and an 8-bit timer overflow. Four are peripheral sources: ADC completion, a capture/compare event and two further timers. Each event sets a sticky flag. The flag is then masked by a per-source enable. Peripheral terms also pass through a group enable, and the result is gated by a global enable to form the request to the core.

When the core accepts the request it pulses an acknowledge. The block then clears the global enable, pulses a push-return-address strobe and a vector-load strobe, and presents the fixed vector 0x0004. A return-from-interrupt strobe sets the global enable again. Flags are only cleared by software, so a flag left set causes an immediate re-entry. A separate wake output reflects the masked flags regardless of the global enable.

The external pin and the port input are asynchronous. Each passes through a two-flop synchronizer, which gives a fixed three-edge latency from a pin transition to its flag.

Top module: `irq_aggregator`

## Requirements
- R1: After reset all flags, all enables and the global enable read 0. The polarity register (address 3) reads 1, meaning rising edge. irq_req, wake, push_ret and vec_load are low.
- R2: An event pulse sets its flag whatever the state of its enable, the group enable or the global enable. Flag bits: address 0 bit0 is external pin, bit1 is port change, bit2 is timer0; address 1 bit0 is ADC, bit1 is capture/compare, bit2 is timer1, bit3 is timer2.
- R3: A core-source request needs flag, enable and global enable only. Address 0 holds bit3 external pin enable, bit4 port-change enable, bit5 timer0 enable, bit6 group enable and bit7 global enable.
- R4: A peripheral-source request additionally needs the group enable. Peripheral enables are held in address 2, in bits 3:0, matching the flag bits.
- R5: wake is high whenever any masked term is active, with peripheral terms also gated by the group enable. wake does not depend on the global enable.
- R6: If irq_ack is high while irq_req is high, then in the next cycle push_ret and vec_load are high for exactly one cycle, vec_addr is 0x0004, the global enable reads 0 and all flags are unchanged.
- R7: A one-cycle irq_ret sets the global enable. If a masked flag is still set, irq_req rises again right away.
- R8: An external pin transition of the selected polarity sets the pin flag on the third rising clock edge after the transition. A transition of the other polarity is ignored. Polarity is address 3 bit0: 1 means rising, 0 means falling.
- R9: A mismatch between the synchronized port and the reference value sets the port-change flag on the third edge. The flag keeps being set while the mismatch lasts. A port_rd pulse copies the port into the reference, after which a clear holds.
- R10: A register write of 0 to a flag bit clears it, and a write of 1 sets it.
- R11: If an event and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R12: irq_ack while irq_req is low has no effect: no strobe is produced and the global enable is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| port_in | input | PORT_W | Asynchronous port watched for change |
| port_rd | input | 1 | Port read strobe; latches the change reference |
| tmr0_ovf | input | 1 | Timer0 overflow event pulse |
| adc_done | input | 1 | ADC completion event pulse |
| ccp_evt | input | 1 | Capture/compare event pulse |
| tmr1_ovf | input | 1 | Timer1 event pulse |
| tmr2_evt | input | 1 | Timer2 event pulse |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write enable |
| reg_rdata | output | 8 | Register read data at reg_addr |
| irq_ack | input | 1 | Core accepts the interrupt |
| irq_ret | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request to the core |
| wake | output | 1 | Wake-from-sleep indication |
| push_ret | output | 1 | Push-return-address strobe |
| vec_load | output | 1 | Load vector into program counter |
| vec_addr | output | VEC_W | Interrupt vector address |

## Verification
The hardest conditions to reach are a flag event that coincides with a software clear of the same flag, and the re-entry that follows a return with a flag still set. The bench reaches the first by driving a capture/compare pulse in the same cycle as a clearing write. It reaches the second by taking an interrupt, leaving the flag alone and then pulsing irq_ret. The port-change case also needs care, because the mismatch keeps re-arming the flag. The stimulus therefore shows that a clear does not hold until a port_rd has moved the reference.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int PORT_W = 4,
  parameter int VEC_W = 13,
  parameter logic [VEC_W-1:0] VECTOR = 13'h0004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_pin,
  input  logic [PORT_W-1:0] port_in,
  input  logic              port_rd,
  input  logic              tmr0_ovf,
  input  logic              adc_done,
  input  logic              ccp_evt,
  input  logic              tmr1_ovf,
  input  logic              tmr2_evt,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_we,
  output logic [7:0]        reg_rdata,
  input  logic              irq_ack,
  input  logic              irq_ret,
  output logic              irq_req,
  output logic              wake,
  output logic              push_ret,
  output logic              vec_load,
  output logic [VEC_W-1:0]  vec_addr
);
  logic [2:0] cflag, cen;
  logic [3:0] pflag, pen;
  logic       gen, grp, rise_sel, take_q;
  logic [2:0] pin_s;
  logic [PORT_W-1:0] port_s1, port_s2, port_ref;

  wire ext_evt = rise_sel ? (pin_s[1] & ~pin_s[2]) : (~pin_s[1] & pin_s[2]);
  wire chg_evt = (port_s2 != port_ref);
  wire [2:0] cevt = {tmr0_ovf, chg_evt, ext_evt};
  wire [3:0] pevt = {tmr2_evt, tmr1_ovf, ccp_evt, adc_done};

  wire wr_core = reg_we && (reg_addr == 2'd0);
  wire wr_pflg = reg_we && (reg_addr == 2'd1);
  wire wr_pen  = reg_we && (reg_addr == 2'd2);
  wire wr_pol  = reg_we && (reg_addr == 2'd3);

  assign wake     = (|(cflag & cen)) | (grp & (|(pflag & pen)));
  assign irq_req  = gen & wake;
  wire   take     = irq_ack & irq_req;
  assign push_ret = take_q;
  assign vec_load = take_q;
  assign vec_addr = VECTOR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_s    <= '0;
      port_s1  <= '0;
      port_s2  <= '0;
      port_ref <= '0;
    end else begin
      pin_s   <= {pin_s[1:0], ext_pin};
      port_s1 <= port_in;
      port_s2 <= port_s1;
      if (port_rd) port_ref <= port_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cflag    <= '0;
      cen      <= '0;
      grp      <= 1'b0;
      gen      <= 1'b0;
      pflag    <= '0;
      pen      <= '0;
      rise_sel <= 1'b1;
      take_q   <= 1'b0;
    end else begin
      cflag  <= cevt | (wr_core ? reg_wdata[2:0] : cflag);
      pflag  <= pevt | (wr_pflg ? reg_wdata[3:0] : pflag);
      take_q <= take;
      if (wr_core) begin
        cen <= reg_wdata[5:3];
        grp <= reg_wdata[6];
      end
      if (wr_pen) pen <= reg_wdata[3:0];
      if (wr_pol) rise_sel <= reg_wdata[0];
      if (take)         gen <= 1'b0;
      else if (irq_ret) gen <= 1'b1;
      else if (wr_core) gen <= reg_wdata[7];
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {gen, grp, cen, cflag};
      2'd1:    reg_rdata = {4'b0, pflag};
      2'd2:    reg_rdata = {4'b0, pen};
      default: reg_rdata = {7'b0, rise_sel};
    endcase
  end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_ack,
  input logic       irq_ret,
  input logic       irq_req,
  input logic       wake,
  input logic       push_ret,
  input logic       vec_load,
  input logic       tmr0_ovf,
  input logic       adc_done,
  input logic       gen,
  input logic [2:0] cflag,
  input logic [3:0] pflag
);
  a_r6_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> (push_ret && vec_load));
  a_r6_gen_off: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> (!gen && !irq_req));
  a_r12_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_ack && irq_req) |=> !push_ret);
  a_r5_req_has_wake: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> wake);
  a_r7_ret_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && !(irq_ack && irq_req)) |=> gen);
  a_r2_t0_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    tmr0_ovf |=> cflag[2]);
  a_r11_adc_wins: assert property (@(posedge clk) disable iff (!rst_n)
    adc_done |=> pflag[0]);
endmodule

bind irq_aggregator irq_aggregator_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack), .irq_ret(irq_ret),
  .irq_req(irq_req), .wake(wake), .push_ret(push_ret), .vec_load(vec_load),
  .tmr0_ovf(tmr0_ovf), .adc_done(adc_done), .gen(gen),
  .cflag(cflag), .pflag(pflag)
);

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  logic clk = 0, rst_n = 0;
  logic ext_pin = 0, port_rd = 0, tmr0_ovf = 0, adc_done = 0, ccp_evt = 0;
  logic tmr1_ovf = 0, tmr2_evt = 0, reg_we = 0, irq_ack = 0, irq_ret = 0;
  logic [3:0] port_in = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq_req, wake, push_ret, vec_load;
  logic [12:0] vec_addr;
  int checks = 0, fails = 0, cycles = 0;

  typedef struct { string tag; int sel; int val; } item_t;
  item_t q[$];
  item_t it;

  irq_aggregator i_irq_aggregator (.*);

  always #10 clk = ~clk;

  always @(negedge clk) begin
    while (q.size() > 0) begin
      int act;
      it = q.pop_front();
      case (it.sel)
        0: act = int'(irq_req);
        1: act = int'(wake);
        2: act = int'(push_ret);
        3: act = int'(vec_load);
        4: act = int'(vec_addr);
        default: act = int'(reg_rdata);
      endcase
      checks++;
      if (act != it.val) begin
        fails++;
        $display("FAIL %s sel=%0d actual=%0h expected=%0h", it.tag, it.sel, act, it.val);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic step(); @(posedge clk); #2; endtask
  task automatic chk(); @(negedge clk); #1; endtask
  task automatic exp(string t, int s, int v); q.push_back('{t, s, v}); endtask
  task automatic peek(string t, logic [1:0] a, int v);
    reg_addr = a; exp(t, 5, v);
  endtask
  task automatic wr(logic [1:0] a, logic [7:0] d);
    step(); reg_we = 1; reg_addr = a; reg_wdata = d;
    step(); reg_we = 0;
  endtask
  task automatic steps(int n); for (int i = 0; i < n; i++) step(); endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    peek("R1 core", 0, 0); exp("R1 req", 0, 0); exp("R1 wake", 1, 0); exp("R1 push", 2, 0); chk();
    peek("R1 pflag", 1, 0); exp("R1 vload", 3, 0); chk();
    peek("R1 pen", 2, 0); chk();
    peek("R1 pol", 3, 1); chk();

    step(); tmr0_ovf = 1; step(); tmr0_ovf = 0;
    peek("R2 t0 flag", 0, 'h04); exp("R2 req", 0, 0); exp("R2 wake", 1, 0); chk();
    step(); adc_done = 1; step(); adc_done = 0;
    peek("R2 adc flag", 1, 'h01); chk();
    wr(1, 0); peek("R10 clear", 1, 0); chk();
    wr(0, 0); peek("R10 clear core", 0, 0); chk();

    wr(0, 8'h24); peek("R10 set", 0, 'h24); exp("R5 wake no gen", 1, 1); exp("R3 no req", 0, 0); chk();
    wr(0, 8'hA4); exp("R3 core req", 0, 1); chk();

    step(); irq_ack = 1; step(); irq_ack = 0;
    exp("R6 push", 2, 1); exp("R6 vload", 3, 1); exp("R6 vec", 4, 4); exp("R6 req off", 0, 0);
    peek("R6 gen clr flags kept", 0, 'h24); chk();
    step(); exp("R6 push one cycle", 2, 0); chk();

    step(); irq_ack = 1; step(); irq_ack = 0;
    exp("R12 no push", 2, 0); peek("R12 gen", 0, 'h24); chk();

    step(); irq_ret = 1; step(); irq_ret = 0;
    exp("R7 reentry", 0, 1); peek("R7 gen", 0, 'hA4); chk();
    wr(0, 8'hA0); exp("R7 req after clear", 0, 0); chk();

    wr(2, 8'h04); step(); tmr1_ovf = 1; step(); tmr1_ovf = 0;
    peek("R2 t1 flag", 1, 'h04); exp("R4 no grp req", 0, 0); exp("R4 no grp wake", 1, 0); chk();
    wr(0, 8'hE0); exp("R4 grp req", 0, 1); exp("R4 grp wake", 1, 1); chk();
    wr(0, 8'hA0); exp("R4 grp off", 0, 0); chk();
    wr(1, 0); wr(0, 0);

    step(); reg_we = 1; reg_addr = 1; reg_wdata = 0; ccp_evt = 1;
    step(); reg_we = 0; ccp_evt = 0;
    peek("R11 event wins", 1, 'h02); chk();
    wr(1, 0);

    wr(0, 8'h08);
    step(); ext_pin = 1;
    step(); peek("R8 e1", 0, 'h08); chk();
    step(); peek("R8 e2", 0, 'h08); chk();
    step(); peek("R8 e3", 0, 'h09); exp("R8 wake", 1, 1); chk();
    wr(0, 8'h08); step(); ext_pin = 0; steps(5);
    peek("R8 fall ignored", 0, 'h08); chk();
    wr(3, 0); step(); ext_pin = 1; steps(5);
    peek("R8 rise ignored in falling", 0, 'h08); chk();
    step(); ext_pin = 0;
    step(); step(); peek("R8 fall e2", 0, 'h08); chk();
    step(); peek("R8 fall e3", 0, 'h09); chk();
    wr(0, 0);

    wr(0, 8'h10);
    step(); port_in = 4'h3;
    step(); step(); peek("R9 e2", 0, 'h10); chk();
    step(); peek("R9 e3", 0, 'h12); exp("R9 wake", 1, 1); chk();
    wr(0, 8'h10); peek("R9 rearm", 0, 'h12); chk();
    step(); port_rd = 1; step(); port_rd = 0;
    wr(0, 8'h10); peek("R9 clear holds", 0, 'h10); exp("R9 wake off", 1, 0); chk();

    step();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule